// File: doc/BRIEF.md
# Sequential 16x16 Multiplier with Operand-Dependent Latency

This block multiplies two 16-bit operands into a 32-bit product, either as unsigned or as signed (two's complement) numbers. It takes a 16-bit instruction word with each request and decodes it. The word selects signed or unsigned operation, names the destination data register, and carries an addressing mode that may be illegal. A legal request makes the unit busy for a number of cycles that depends on the source operand, the way a microcoded processor spends its multiply time.

The base cost is 34 cycles. An unsigned multiply adds two cycles for every 1 bit in the source. A signed multiply adds two cycles for every 0/1 transition in the source, with an implied 0 below bit 0. The product, its negative and zero flags, the destination register number and the latency charged are all presented together with a one-cycle done pulse on the last cycle of that latency. Overflow and carry always read 0.

Requests use a valid/ready handshake. `in_ready` is high only while the unit is idle. A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. A request offered while `in_ready` is low is not taken, and the unit keeps no record of it. The result side has no back-pressure: `out_valid` is a single-cycle pulse. The result registers then hold their value until the next legal request completes.

Top module: `seqmul_unit`

## Requirements
- R1: A request is taken on a rising edge with `in_valid` and `in_ready` both high. The word is legal when bits [15:12] are 1100 and bits [7:6] are 11. Bit 8 set selects signed, clear selects unsigned. Bits [11:9] appear on `out_dreg` with the result.
- R2: Mode is bits [5:3] and register is bits [2:0]. A taken word is illegal if its mode is 1, if its mode is 7 with register 5, 6 or 7, or if it fails the R1 pattern. It then pulses `out_illegal` for one cycle right after the taking edge. The unit does not go busy, and the result, flags, `out_dreg` and `out_cycles` stay unchanged.
- R3: An unsigned multiply gives the 32-bit product of both operands taken as unsigned numbers.
- R4: A signed multiply sign-extends both operands and gives the low 32 bits of their product.
- R5: With the result, `out_neg` equals result bit 31, `out_zero` is set exactly when the result is 0, and `out_ovf` and `out_carry` are 0.
- R6: The latency L of an unsigned multiply is 34 + 2 × (number of 1 bits in the source).
- R7: The latency L of a signed multiply is 34 + 2 × (number of 1 bits in ((source << 1) XOR source), truncated to 16 bits).
- R8: Count the cycle after the taking edge as cycle 1. `in_ready` is low in cycles 1 through L. `out_valid` is high only in cycle L, and that cycle already shows the new result and flags. `in_ready` is high again in cycle L+1.
- R9: A request offered while busy is not taken. The result, `out_dreg` and `out_cycles` come from the request already running.
- R10: After reset, `in_ready` is 1, and `out_valid`, `out_illegal`, the result, the flags, `out_dreg` and `out_cycles` are 0.
- R11: `out_cycles` shows the latency L of the last legal request from the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle and able to take a request |
| in_opword | input | 16 | Instruction word of the request |
| in_src | input | 16 | Source operand (sets the latency) |
| in_dst | input | 16 | Destination register operand |
| out_valid | output | 1 | One-cycle done pulse on the final busy cycle |
| out_result | output | 32 | Product |
| out_neg | output | 1 | Negative flag |
| out_zero | output | 1 | Zero flag |
| out_ovf | output | 1 | Overflow flag, always 0 |
| out_carry | output | 1 | Carry flag, always 0 |
| out_dreg | output | 3 | Destination register field of the finished request |
| out_cycles | output | 7 | Latency charged to the last legal request |
| out_illegal | output | 1 | One-cycle pulse: taken word was rejected |

## Verification
Two events can fall in the same cycle: the done pulse of one multiply and a new request offered by a caller who is already waiting. The bench raises `in_valid` with a second operation in the very cycle `out_valid` is high and keeps it raised. It judges three things. First, the request must not be taken at that edge, because `in_ready` is still low. Second, it must be taken one cycle later. Third, its own latency must be counted from that later edge, while the first result stays intact until the second one completes.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
  localparam int OPWORD_W = 16;

  // addressing-mode field values that matter for legality
  localparam logic [2:0] MODE_ADDR_REG  = 3'd1;
  localparam logic [2:0] MODE_EXTENDED  = 3'd7;
  localparam logic [2:0] EXT_FIRST_BAD  = 3'd5;

  typedef struct packed {
    logic       ok;
    logic       sgn;
    logic [2:0] dreg;
  } mul_dec_t;
endpackage

// File: rtl/seqmul_decode.sv
module seqmul_decode
  import seqmul_pkg::*;
(
  input  logic [OPWORD_W-1:0] opword,
  output mul_dec_t            dec
);
  logic [2:0] mode_f;
  logic [2:0] reg_f;
  logic       family;
  logic       bad_mode;

  always_comb begin
    mode_f   = opword[5:3];
    reg_f    = opword[2:0];
    family   = (opword[15:12] == 4'b1100) && (opword[7:6] == 2'b11);
    bad_mode = (mode_f == MODE_ADDR_REG) ||
               ((mode_f == MODE_EXTENDED) && (reg_f >= EXT_FIRST_BAD));
    dec.ok   = family && !bad_mode;
    dec.sgn  = opword[8];
    dec.dreg = opword[11:9];
  end
endmodule

// File: rtl/seqmul_popcnt.sv
module seqmul_popcnt #(
  parameter int W  = 16,
  localparam int LV = $clog2(W),
  localparam int PW = LV + 1
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] count
);
  function automatic logic [W-1:0] lo_mask(input int s);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (((i >> s) & 1) == 0);
    return m;
  endfunction

  logic [W-1:0] lvl [LV+1];
  assign lvl[0] = vec;

  for (genvar s = 0; s < LV; s++) begin : g_stage
    localparam int           SH = 1 << s;
    localparam logic [W-1:0] LO = lo_mask(s);
    assign lvl[s+1] = (lvl[s] & LO) + ((lvl[s] >> SH) & LO);
  end

  assign count = lvl[LV][PW-1:0];
endmodule

// File: rtl/seqmul_latency.sv
module seqmul_latency #(
  parameter int OPW  = 16,
  parameter int CNTW = 7,
  localparam int BASE = 2 * OPW + 2,
  localparam int PW   = $clog2(OPW) + 1
) (
  input  logic [OPW-1:0]  src,
  input  logic            sgn,
  output logic [CNTW-1:0] lat
);
  logic [OPW-1:0] pattern;
  logic [PW-1:0]  ones;

  // signed mode counts edges between neighbouring bits (implied 0 below bit 0)
  assign pattern = sgn ? (OPW'(src << 1) ^ src) : src;

  seqmul_popcnt #(.W(OPW)) u_pop (.vec(pattern), .count(ones));

  assign lat = CNTW'(BASE) + CNTW'({ones, 1'b0});
endmodule

// File: rtl/seqmul_timer.sv
module seqmul_timer #(
  parameter int CNTW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CNTW-1:0] load_val,
  output logic            busy,
  output logic            last,
  output logic            commit
);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (busy)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy   = (cnt_q != '0);
  assign last   = (cnt_q == CNTW'(1));
  // result registers load on the edge that enters the final cycle
  assign commit = (cnt_q == CNTW'(2));
endmodule

// File: rtl/seqmul_core.sv
module seqmul_core #(
  parameter int OPW = 16,
  localparam int RW = 2 * OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           commit,
  input  logic [OPW-1:0] src,
  input  logic [OPW-1:0] dst,
  input  logic           sgn,
  input  logic [2:0]     dreg,
  output logic [RW-1:0]  result,
  output logic           neg,
  output logic           zero,
  output logic [2:0]     dreg_out
);
  logic signed [RW-1:0] prod_s;
  logic        [RW-1:0] prod_u;
  logic        [RW-1:0] pend_q;
  logic        [2:0]    pend_dreg_q;

  always_comb begin
    prod_s = $signed(src) * $signed(dst);
    prod_u = {{OPW{1'b0}}, src} * {{OPW{1'b0}}, dst};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      pend_dreg_q <= '0;
    end else if (take) begin
      pend_q      <= sgn ? RW'(prod_s) : prod_u;
      pend_dreg_q <= dreg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      neg      <= 1'b0;
      zero     <= 1'b0;
      dreg_out <= '0;
    end else if (commit) begin
      result   <= pend_q;
      neg      <= pend_q[RW-1];
      zero     <= (pend_q == '0);
      dreg_out <= pend_dreg_q;
    end
  end
endmodule

// File: rtl/seqmul_unit.sv
module seqmul_unit
  import seqmul_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int CNTW = $clog2(4 * OPW + 3)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OPWORD_W-1:0] in_opword,
  input  logic [OPW-1:0]      in_src,
  input  logic [OPW-1:0]      in_dst,
  output logic                out_valid,
  output logic [2*OPW-1:0]    out_result,
  output logic                out_neg,
  output logic                out_zero,
  output logic                out_ovf,
  output logic                out_carry,
  output logic [2:0]          out_dreg,
  output logic [CNTW-1:0]     out_cycles,
  output logic                out_illegal
);
  mul_dec_t        dec;
  logic            accept, take, busy, last, commit;
  logic [CNTW-1:0] lat;
  logic [CNTW-1:0] cycles_q;
  logic            illegal_q;

  seqmul_decode u_dec (.opword(in_opword), .dec(dec));

  seqmul_latency #(.OPW(OPW), .CNTW(CNTW)) u_lat (
    .src(in_src), .sgn(dec.sgn), .lat(lat)
  );

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign take     = accept && dec.ok;

  seqmul_timer #(.CNTW(CNTW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(take), .load_val(lat),
    .busy(busy), .last(last), .commit(commit)
  );

  seqmul_core #(.OPW(OPW)) u_core (
    .clk(clk), .rst_n(rst_n), .take(take), .commit(commit),
    .src(in_src), .dst(in_dst), .sgn(dec.sgn), .dreg(dec.dreg),
    .result(out_result), .neg(out_neg), .zero(out_zero), .dreg_out(out_dreg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycles_q  <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && !dec.ok;
      if (take) cycles_q <= lat;
    end
  end

  assign out_valid   = last;
  assign out_cycles  = cycles_q;
  assign out_illegal = illegal_q;
  assign out_ovf     = 1'b0;
  assign out_carry   = 1'b0;
endmodule

// File: rtl/seqmul_unit_chk.sv
module seqmul_unit_chk #(
  parameter int OPW  = 16,
  parameter int CNTW = 7,
  localparam int BASE = 2 * OPW + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [2*OPW-1:0]  out_result,
  input logic              out_neg,
  input logic              out_zero,
  input logic [CNTW-1:0]   out_cycles,
  input logic              out_illegal
);
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R8
  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R8
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> in_ready); // R8
  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (in_ready && !out_valid)); // R2
  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> ($stable(out_result) && $stable(out_cycles))); // R2
  AST_FLAGS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_neg == out_result[2*OPW-1]) && (out_zero == (out_result == '0)))); // R5
  AST_LAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cycles >= CNTW'(BASE))); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(out_cycles)); // R9
endmodule

bind seqmul_unit seqmul_unit_chk #(.OPW(OPW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_result(out_result), .out_neg(out_neg),
  .out_zero(out_zero), .out_cycles(out_cycles), .out_illegal(out_illegal)
);

// File: tb/seqmul_unit_tb.sv
`timescale 1ns/1ps
module seqmul_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_opword = '0, in_src = '0, in_dst = '0;
  logic        out_valid, out_neg, out_zero, out_ovf, out_carry, out_illegal;
  logic [31:0] out_result;
  logic [2:0]  out_dreg;
  logic [6:0]  out_cycles;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  seqmul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opword(in_opword), .in_src(in_src), .in_dst(in_dst),
    .out_valid(out_valid), .out_result(out_result), .out_neg(out_neg),
    .out_zero(out_zero), .out_ovf(out_ovf), .out_carry(out_carry),
    .out_dreg(out_dreg), .out_cycles(out_cycles), .out_illegal(out_illegal)
  );

  localparam int NV = 8;
  localparam logic [15:0] T_SRC [NV] = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555,
                                          16'h8001, 16'h1234, 16'h7FFF, 16'h0F0F};
  localparam logic [15:0] T_DST [NV] = '{16'h1234, 16'hFFFF, 16'h5555, 16'hAAAA,
                                          16'h8000, 16'h0000, 16'hFFFE, 16'h00FF};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_lat(input logic [15:0] s, input bit sg);
    logic [15:0] p;
    int n;
    p = sg ? ({s[14:0], 1'b0} ^ s) : s;
    n = 0;
    for (int i = 0; i < 16; i++) n += int'(p[i]);
    return 34 + 2 * n;
  endfunction

  function automatic logic [31:0] ref_prod(input logic [15:0] s, input logic [15:0] d, input bit sg);
    logic [31:0] a, b;
    a = sg ? {{16{s[15]}}, s} : {16'h0, s};
    b = sg ? {{16{d[15]}}, d} : {16'h0, d};
    return a * b;
  endfunction

  function automatic logic [15:0] mk_op(input logic [2:0] dr, input bit sg,
                                         input logic [2:0] md, input logic [2:0] rg);
    return {4'hC, dr, sg, 2'b11, md, rg};
  endfunction

  // offer one request at a negedge, take it at the next edge, count cycles to done
  task automatic run_mul(input logic [15:0] ow, input logic [15:0] s, input logic [15:0] d,
                         output int lat);
    bit ready_bad;
    @(negedge clk);
    in_opword = ow; in_src = s; in_dst = d; in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    lat = 0; ready_bad = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); lat++;
      if (in_ready) ready_bad = 1;
      if (out_valid) break;
    end
    chk("R8 in_ready low through done cycle", 64'(ready_bad), 64'd0);
    @(negedge clk);
    chk("R8 in_ready back after done", 64'(in_ready), 64'd1);
    chk("R8 done is one cycle", 64'(out_valid), 64'd0);
  endtask

  task automatic full_check(input logic [15:0] s, input logic [15:0] d, input bit sg,
                            input logic [2:0] dr);
    int lat;
    logic [31:0] e;
    e = ref_prod(s, d, sg);
    run_mul(mk_op(dr, sg, 3'd0, 3'd2), s, d, lat);
    chk(sg ? "R4 signed product" : "R3 unsigned product", 64'(out_result), 64'(e));
    chk(sg ? "R7 signed latency" : "R6 unsigned latency", 64'(lat), 64'(ref_lat(s, sg)));
    chk("R11 out_cycles", 64'(out_cycles), 64'(ref_lat(s, sg)));
    chk("R5 flags NZVC", {60'd0, out_neg, out_zero, out_ovf, out_carry},
        {60'd0, e[31], (e == 32'd0), 2'b00});
    chk("R1 dreg echo", 64'(out_dreg), 64'(dr));
  endtask

  task automatic illegal_check(input logic [15:0] ow, input string what);
    logic [31:0] r0;
    logic [6:0]  c0;
    logic [2:0]  d0;
    r0 = out_result; c0 = out_cycles; d0 = out_dreg;
    @(negedge clk);
    in_opword = ow; in_src = 16'hFFFF; in_dst = 16'h7777; in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk({"R2 illegal pulse ", what}, 64'(out_illegal), 64'd1);
    chk({"R2 stays idle ", what}, 64'(in_ready), 64'd1);
    repeat (3) @(negedge clk);
    chk({"R2 pulse one cycle ", what}, 64'(out_illegal), 64'd0);
    chk({"R2 state kept ", what}, {22'd0, out_dreg, out_cycles, out_result},
        {22'd0, d0, c0, r0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs",
        {out_result, 7'd0, out_cycles, 3'd0, out_dreg, 2'd0, in_ready, out_valid,
         out_illegal, out_neg, out_zero, out_ovf},
        {32'd0, 7'd0, 7'd0, 3'd0, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      full_check(T_SRC[i], T_DST[i], 1'b0, 3'(i));
      full_check(T_SRC[i], T_DST[i], 1'b1, 3'(7 - i));
    end
    for (int i = 0; i < 6; i++) begin
      logic [15:0] s, d;
      s = 16'($urandom); d = 16'($urandom);
      full_check(s, d, i[0], 3'(i));
    end

    // extended mode with register 4 is legal (R1)
    run_mul(mk_op(3'd5, 1'b0, 3'd7, 3'd4), 16'h0003, 16'h0005, lat);
    chk("R1 mode7 reg4 legal", 64'(out_result), 64'd15);

    // R2 illegal forms
    illegal_check(mk_op(3'd1, 1'b0, 3'd1, 3'd0), "mode1 unsigned");
    illegal_check(mk_op(3'd1, 1'b1, 3'd1, 3'd3), "mode1 signed");
    illegal_check(mk_op(3'd2, 1'b0, 3'd7, 3'd5), "m7r5");
    illegal_check(mk_op(3'd2, 1'b1, 3'd7, 3'd6), "m7r6");
    illegal_check(mk_op(3'd2, 1'b0, 3'd7, 3'd7), "m7r7");
    illegal_check(16'h4E71, "foreign word");
    illegal_check(16'hC0C0 & 16'hFF7F & 16'hFFBF, "bits76 not 11");

    // R9: request offered mid-operation is dropped
    @(negedge clk);
    in_opword = mk_op(3'd3, 1'b0, 3'd0, 3'd0); in_src = 16'h0003; in_dst = 16'h0007; in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    repeat (5) @(negedge clk);
    in_opword = mk_op(3'd6, 1'b1, 3'd0, 3'd0); in_src = 16'hFFFF; in_dst = 16'h0100; in_valid = 1'b1;
    @(negedge clk);
    chk("R9 not ready while busy", 64'(in_ready), 64'd0);
    in_valid = 1'b0;
    lat = 6;
    for (int k = 0; k < 200; k++) begin
      if (out_valid) break;
      @(negedge clk); lat++;
    end
    chk("R9 first op result kept", 64'(out_result), 64'd21);
    chk("R9 first op latency", 64'(lat), 64'(ref_lat(16'h0003, 1'b0)));
    chk("R9 first op cycles/dreg", {out_dreg, out_cycles}, {3'd3, 7'(ref_lat(16'h0003, 1'b0))});

    // same cycle: done pulse and a waiting caller
    @(negedge clk);
    in_opword = mk_op(3'd2, 1'b0, 3'd0, 3'd0); in_src = 16'h00FF; in_dst = 16'h0002; in_valid = 1'b1;
    @(posedge clk); #1;
    in_opword = mk_op(3'd4, 1'b1, 3'd0, 3'd0); in_src = 16'h0F00; in_dst = 16'hFFFF;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (out_valid) break;
    end
    chk("R8 done shows first result", 64'(out_result), 64'h1FE);
    @(negedge clk);
    chk("R8 waiting request not yet taken", {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1 in_valid = 1'b0;
    lat = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); lat++;
      if (out_valid) break;
      if (k == 0) chk("R8 first result held while second runs", 64'(out_result), 64'h1FE);
    end
    chk("R7 second op latency from later edge", 64'(lat), 64'(ref_lat(16'h0F00, 1'b1)));
    chk("R4 second op product", 64'(out_result), 64'(ref_prod(16'h0F00, 16'hFFFF, 1'b1)));
    chk("R1 second op dreg", 64'(out_dreg), 64'd4);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule